// File: doc/BRIEF.md
# Iterative Factorial Register Unit

This block is a small memory-mapped register unit that sits behind a simple word-access register bus. It holds a fixed identification word and a scratch register that stores the inverse of whatever is written, so that software can check that the bus path is alive. It also holds a factorial accelerator. Software writes an operand into the shared operand/result word. The unit then multiplies one factor per clock cycle while a busy flag in the status word stays set. When it finishes, the truncated 32-bit product overwrites the operand in that same word.

Software either polls the busy flag or sets an enable bit in the status word. When that bit is set, the unit emits a single-cycle completion pulse for an interrupt aggregator outside the block. The unit honours only 4-byte accesses inside a 128-byte window. Reads that miss the register set return all ones, and writes that miss it change nothing.

Top module: `fact_regblock`

## Requirements
- R1: A 4-byte read at offset 0x00 returns 0x010000ED.
- R2: A 4-byte write at offset 0x04 stores the bitwise inverse of the write data, and a read at 0x04 returns the stored value. The reset value is 0.
- R3: A 4-byte write at offset 0x08 while idle loads the write data and sets busy (status bit 0). Such a write while busy is ignored.
- R4: The result is n×(n−1)×…×1 modulo 2^32, and an operand of 0 gives 1. Busy reads as set for exactly n+1 cycles, starting in the cycle after the write edge.
- R5: While busy, a read of 0x08 returns the loaded operand. In the cycle in which busy first reads clear, 0x08 already returns the result.
- R6: Status bit 7 (offset 0x20) is written from write-data bit 7. A status write changes no other bit, and status bits other than 0 and 7 read as 0.
- R7: `fact_irq` is high for exactly one cycle, which is the first cycle in which busy reads clear, and only if status bit 7 was set when the computation finished.
- R8: Only accesses with `bus_size` = 2 (size code = log2 of the byte count) and an offset below 0x80 are honoured. Any other access, and any access to an offset that holds no register, reads 0xFFFFFFFF and has no effect when written.
- R9: After reset, busy, status bit 7, the operand/result word, the scratch word and `fact_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (20) | Byte offset inside the 1 MiB window |
| bus_size | input | 2 | log2 of the access size in bytes |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from the current access |
| fact_irq | output | 1 | One-cycle completion pulse |

## Verification
A counter that skips or repeats a step shows up at the ports within one computation: the busy window is longer or shorter than n+1 cycles, and the product read back from 0x08 is wrong. A stuck busy flag blocks all later operand loads. A busy flag that clears early exposes a partial product in 0x08 on the first idle read. A wrong enable or pulse register is visible in the first idle cycle, where `fact_irq` is missing, arrives without the enable, or lasts two cycles. A decode fault appears on the very next access as a read that is not all ones, or as a register that changed.

// File: rtl/fact_pkg.sv
package fact_pkg;
    localparam logic [31:0] ID_VALUE   = 32'h010000ED;
    localparam int          WIN_LIMIT  = 'h80;
    localparam logic [1:0]  SIZE_WORD  = 2'd2;
    localparam int          NUM_REGS   = 4;
    localparam int          REG_ID     = 0;
    localparam int          REG_LIVE   = 1;
    localparam int          REG_FACT   = 2;
    localparam int          REG_STAT   = 3;
    localparam int          REG_OFFS [NUM_REGS] = '{'h00, 'h04, 'h08, 'h20};
    localparam int          STAT_BUSY  = 0;
    localparam int          STAT_IRQEN = 7;
endpackage

// File: rtl/fact_decode.sv
module fact_decode
    import fact_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          size,
    output logic [NUM_REGS-1:0] sel
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(WIN_LIMIT);

    logic in_window;
    assign in_window = (size == SIZE_WORD) && (addr < LIMIT);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign sel[g] = in_window && (addr == ADDR_W'(REG_OFFS[g]));
    end

    // R8: at most one register is addressed by any access
    a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    // R8: an access outside the window selects nothing
    a_r8_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= LIMIT) |-> (sel == '0));
endmodule

// File: rtl/fact_engine.sv
module fact_engine #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    output logic              busy,
    output logic              finish,
    output logic [DATA_W-1:0] result
);
    typedef struct packed {
        logic              busy;
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] acc;
    } eng_t;

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    eng_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        finish = st_q.busy && (st_q.cnt == '0);
        if (start && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.cnt  = operand;
            st_d.acc  = ONE;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.acc = st_q.acc * st_q.cnt;
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign result = st_q.acc;

    // R4: the operand counts down by one per busy cycle
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != '0) |=> (st_q.busy && st_q.cnt == $past(st_q.cnt) - ONE));
    // R5: busy drops right after the finishing cycle
    a_r5_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !st_q.busy);
    // R3: a start while busy does not reload the counter
    a_r3_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (start && st_q.busy && st_q.cnt != '0) |=> (st_q.cnt != $past(operand) || $past(operand) == $past(st_q.cnt) - ONE));
endmodule

// File: rtl/fact_regblock.sv
module fact_regblock
    import fact_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              fact_irq
);
    typedef struct packed {
        logic [DATA_W-1:0] live;
        logic [DATA_W-1:0] fact;
        logic              irqen;
        logic              irq;
    } regs_t;

    regs_t reg_d, reg_q;

    logic [NUM_REGS-1:0] sel;
    logic                wr, rd, start, busy, finish;
    logic [DATA_W-1:0]   result, stat_word;

    fact_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .size  (bus_size),
        .sel   (sel)
    );

    assign wr    = bus_valid && bus_write;
    assign rd    = bus_valid && !bus_write;
    assign start = wr && sel[REG_FACT] && !busy;

    fact_engine #(.DATA_W(DATA_W)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .operand (bus_wdata),
        .busy    (busy),
        .finish  (finish),
        .result  (result)
    );

    always_comb begin
        reg_d = reg_q;
        if (wr && sel[REG_LIVE]) begin
            reg_d.live = ~bus_wdata;
        end
        if (start) begin
            reg_d.fact = bus_wdata;
        end else if (finish) begin
            reg_d.fact = result;
        end
        if (wr && sel[REG_STAT]) begin
            reg_d.irqen = bus_wdata[STAT_IRQEN];
        end
        reg_d.irq = finish && reg_q.irqen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    always_comb begin
        stat_word             = '0;
        stat_word[STAT_BUSY]  = busy;
        stat_word[STAT_IRQEN] = reg_q.irqen;
    end

    always_comb begin
        bus_rdata = '1;
        if (rd) begin
            unique case (1'b1)
                sel[REG_ID]:   bus_rdata = DATA_W'(ID_VALUE);
                sel[REG_LIVE]: bus_rdata = reg_q.live;
                sel[REG_FACT]: bus_rdata = reg_q.fact;
                sel[REG_STAT]: bus_rdata = stat_word;
                default:       bus_rdata = '1;
            endcase
        end
    end

    assign fact_irq = reg_q.irq;

    // R1: identification read
    a_r1_id_value: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_size == SIZE_WORD && bus_addr == '0) |-> (bus_rdata == DATA_W'(ID_VALUE)));
    // R2: scratch write stores the inverse
    a_r2_live_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel[REG_LIVE]) |=> (reg_q.live == ~$past(bus_wdata)));
    // R3: operand word is untouched by a write while busy
    a_r3_busy_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> $stable(reg_q.fact));
    // R7: pulse only after a finish with enable set
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fact_irq |-> ($past(finish) && $past(reg_q.irqen)));
    // R7: pulse lasts a single cycle
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        fact_irq |=> !fact_irq);
    // R8: rejected access reads all ones
    a_r8_reject_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_size != SIZE_WORD) |-> (bus_rdata == '1));
endmodule

// File: tb/fact_regblock_test.sv
module fact_regblock_test;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 32;
    localparam logic [19:0] A_ID = 20'h00, A_LIVE = 20'h04, A_FACT = 20'h08, A_STAT = 20'h20;
    localparam int NVEC = 8;
    localparam logic [31:0] OPS [NVEC] = '{32'd0, 32'd1, 32'd2, 32'd5, 32'd10, 32'd12, 32'd13, 32'd34};
    localparam logic        ENS [NVEC] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [1:0] bus_size = 2'd2;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic fact_irq;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fact_regblock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .fact_irq(fact_irq)
    );

    function automatic logic [31:0] ref_fact(input logic [31:0] n);
        logic [31:0] r = 32'd1;
        for (int i = 1; i <= int'(n); i++) r = r * 32'(i);
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [19:0] a, input logic [31:0] d, input logic [1:0] s);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_size = s;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_size = 2'd2;
    endtask

    task automatic bus_rd(input logic [19:0] a, input logic [1:0] s, output logic [31:0] v);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = s;
        #1;
        v = bus_rdata;
        bus_valid = 1'b0; bus_size = 2'd2;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        logic [31:0] v, s;
        int n;
        bit early;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        bus_rd(A_STAT, 2'd2, v); chk("R9 status", v, 32'h0);
        bus_rd(A_FACT, 2'd2, v); chk("R9 fact word", v, 32'h0);
        bus_rd(A_LIVE, 2'd2, v); chk("R9 live word", v, 32'h0);
        chk("R9 irq", 32'(fact_irq), 32'h0);
        // R1
        bus_rd(A_ID, 2'd2, v); chk("R1 id", v, 32'h010000ED);
        // R2
        bus_wr(A_LIVE, 32'h12345678, 2'd2);
        bus_rd(A_LIVE, 2'd2, v); chk("R2 live inverse", v, 32'hEDCBA987);

        // R4/R5/R7 vector table
        for (int k = 0; k < NVEC; k++) begin
            bus_wr(A_STAT, ENS[k] ? 32'h80 : 32'h0, 2'd2);
            bus_wr(A_FACT, OPS[k], 2'd2);
            bus_rd(A_STAT, 2'd2, s);
            n = 0; early = 1'b0;
            while (s[0] && n < 200) begin
                if (fact_irq) early = 1'b1;
                if (n == 0) begin
                    bus_rd(A_FACT, 2'd2, v); chk("R5 operand while busy", v, OPS[k]);
                end
                n++;
                @(negedge clk);
                bus_rd(A_STAT, 2'd2, s);
            end
            chk("R4 busy cycles", 32'(n), OPS[k] + 32'd1);
            chk("R7 no early irq", 32'(early), 32'h0);
            chk("R7 irq at done", 32'(fact_irq), 32'(ENS[k]));
            bus_rd(A_FACT, 2'd2, v); chk("R4 R5 result", v, ref_fact(OPS[k]));
            @(negedge clk);
            chk("R7 irq one cycle", 32'(fact_irq), 32'h0);
        end

        // R3: write while busy ignored; R6: status write keeps busy
        bus_wr(A_STAT, 32'h0, 2'd2);
        bus_wr(A_FACT, 32'd10, 2'd2);
        bus_wr(A_FACT, 32'd3, 2'd2);
        bus_rd(A_FACT, 2'd2, v); chk("R3 load ignored while busy", v, 32'd10);
        bus_wr(A_STAT, 32'hFFFFFF7E, 2'd2);
        bus_rd(A_STAT, 2'd2, v); chk("R6 only bit7 written", v, 32'h1);
        bus_wr(A_STAT, 32'h0000FF80, 2'd2);
        bus_rd(A_STAT, 2'd2, v); chk("R6 bit7 set, others zero", v, 32'h81);
        n = 0;
        bus_rd(A_STAT, 2'd2, s);
        while (s[0] && n < 200) begin n++; @(negedge clk); bus_rd(A_STAT, 2'd2, s); end
        chk("R7 irq with late enable", 32'(fact_irq), 32'h1);
        bus_rd(A_FACT, 2'd2, v); chk("R3 result of first operand", v, 32'd3628800);

        // R8 access filtering
        bus_wr(A_LIVE, 32'h0, 2'd3);
        bus_rd(A_LIVE, 2'd2, v); chk("R8 wide write ignored", v, 32'hEDCBA987);
        bus_wr(A_LIVE, 32'h0, 2'd1);
        bus_rd(A_LIVE, 2'd2, v); chk("R8 narrow write ignored", v, 32'hEDCBA987);
        bus_rd(A_ID, 2'd1, v); chk("R8 narrow read ones", v, 32'hFFFFFFFF);
        bus_rd(A_ID, 2'd3, v); chk("R8 wide read ones", v, 32'hFFFFFFFF);
        bus_rd(20'h80, 2'd2, v); chk("R8 above window ones", v, 32'hFFFFFFFF);
        bus_rd(20'h0C, 2'd2, v); chk("R8 unmapped ones", v, 32'hFFFFFFFF);
        bus_wr(20'h84, 32'd4, 2'd2);
        bus_rd(A_STAT, 2'd2, v); chk("R8 write above window no start", v, 32'h80);
        bus_wr(A_FACT, 32'd4, 2'd1);
        bus_rd(A_STAT, 2'd2, v); chk("R8 narrow operand write no start", v, 32'h80);

        finished = 1'b1;
        summary();
    end
endmodule